// File: doc/BRIEF.md
# Ethernet Payload Channel Extractor

This block sits on the receive side of a 10G Ethernet MAC's 64-bit user stream. It watches each arriving Ethernet II frame. It drops frames whose type field differs from a configured value. For a matching frame it captures a fixed 84-byte custom payload that follows the 14-byte header. The key-data part of that payload is split into twelve 5-byte channels. All twelve channels are presented together, with a single-cycle strobe, in the stream's clock domain.

The 20-byte test signature at the tail of the payload comes out unchanged on its own bus. The destination address, source address and type field of the same frame come out the same way. The block never stalls the MAC. A frame that ends before its payload is complete is reported with a one-cycle error pulse, and it leaves every output untouched.

Top module: `eth_payload_fanout`

## Requirements
- R1: While `rst_ni` is low and after its release, `ch_valid_o` and `err_o` are low, and the data, signature and header outputs read zero until the first complete frame.
- R2: `s_tready_o` is high in every cycle, so a beat is accepted whenever `s_tvalid_i` is high.
- R3: Frame byte n travels in the beat numbered n/8 (counting from 0 at the frame start) on lane n%8, at `s_tdata_i[8*(n%8)+:8]`. Bytes 0–5 are the destination address, with byte 0 at `dst_mac_o[47:40]` and byte 5 at `dst_mac_o[7:0]`. Bytes 6–11 are the source address on `src_mac_o`, in the same order. `type_o` is {byte 12, byte 13}.
- R4: A frame whose type value {byte 12, byte 13} differs from `cfg_type_i` produces no strobe and no error, and it leaves all outputs unchanged.
- R5: Payload byte p is frame byte 14+p. Channel k (0 to 11) is payload bytes 5k to 5k+4. Payload byte 5k+j appears at `ch_data_o[40*k+8*j+:8]`.
- R6: Payload bytes 64–83 appear unchanged on `sig_o`, with payload byte 64+j at `sig_o[8*j+:8]`. Payload bytes 60–63 reach no output.
- R7: `ch_valid_o` is high for exactly one cycle. That cycle is two clock edges after the edge that accepts frame byte 97 (beat 12, lane 1). All data, signature and header outputs change at that same edge and hold at every other edge.
- R8: A matching frame, or a frame shorter than 14 bytes, that ends with `s_tlast_i` before frame byte 97 arrives raises `err_o` for one cycle. The pulse comes in the cycle after the last beat is accepted. The frame produces no strobe.
- R9: Bytes after frame byte 97 are ignored. A longer frame still strobes at byte 97 and raises no error when it ends.
- R10: Cycles with `s_tvalid_i` low do not advance the frame position.
- R11: On the final beat only the lanes with `s_tkeep_i` set count as received. A frame whose beat 12 carries tkeep 8'h01 is short, and it raises `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stream clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_type_i | input | 16 | Type value a frame must carry to be parsed |
| s_tvalid_i | input | 1 | Receive beat valid |
| s_tready_o | output | 1 | Always high |
| s_tdata_i | input | 64 | Receive beat data, lane 0 first |
| s_tkeep_i | input | 8 | Valid byte lanes of the beat |
| s_tlast_i | input | 1 | Last beat of the frame |
| ch_valid_o | output | 1 | One-cycle strobe for a new set of channel outputs |
| ch_data_o | output | 480 | Twelve 40-bit channels, channel 0 in the low bits |
| sig_o | output | 160 | Test signature bytes |
| dst_mac_o | output | 48 | Destination address of the strobed frame |
| src_mac_o | output | 48 | Source address of the strobed frame |
| type_o | output | 16 | Type field of the strobed frame |
| err_o | output | 1 | One-cycle pulse for a short frame |

## Verification
The assertions assume two things about the inputs. First, `s_tkeep_i` is all ones on every beat except the one carrying `s_tlast_i`, and on that beat it is packed from lane 0 upward. Second, `cfg_type_i` does not change while frames are arriving; the strobe-to-type relation depends on that.

The stimulus builds every frame from a byte list cut into beats of eight. Any remainder goes on a final, low-packed beat. The bench holds one type value for the whole run. Idle cycles are placed only between beats, never inside one, so the reference model's byte count always matches the wire.

// File: rtl/eth_pcx_pkg.sv
package eth_pcx_pkg;
  localparam int HDR_BYTES = 14;
  localparam int TYPE_OFS  = 12;

  typedef enum logic {
    ST_PARSE = 1'b0,
    ST_SKIP  = 1'b1
  } trk_state_e;
endpackage

// File: rtl/pcx_frame_tracker.sv
module pcx_frame_tracker
  import eth_pcx_pkg::*;
#(
  parameter int LAST_BEAT = 12,
  parameter int TYPE_BEAT = 1,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             last_i,
  input  logic             keep_type_i,  // second type byte present
  input  logic             keep_end_i,   // final payload byte present
  input  logic [15:0]      type_val_i,
  input  logic [15:0]      cfg_type_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             cap_en_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] BEAT_MAX = CNT_W'(LAST_BEAT + 1);

  trk_state_e       state_q;
  logic [CNT_W-1:0] beat_q;
  logic             parse;
  logic             hdr_bad;
  logic             complete;

  assign parse    = (state_q == ST_PARSE);
  assign hdr_bad  = fire_i && parse && (beat_q == CNT_W'(TYPE_BEAT)) && keep_type_i
                    && (type_val_i != cfg_type_i);
  assign complete = fire_i && parse && (beat_q == CNT_W'(LAST_BEAT)) && keep_end_i;

  assign done_o   = complete;
  assign err_o    = fire_i && parse && last_i && !complete && !hdr_bad;
  assign beat_o   = beat_q;
  assign cap_en_o = parse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PARSE;
      beat_q  <= '0;
    end else if (fire_i) begin
      if (last_i) begin
        state_q <= ST_PARSE;
        beat_q  <= '0;
      end else begin
        if (complete || hdr_bad) state_q <= ST_SKIP;
        if (beat_q != BEAT_MAX) beat_q <= beat_q + 1'b1;
      end
    end
  end

  assert_gap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(beat_o));
endmodule

// File: rtl/pcx_byte_capture.sv
module pcx_byte_capture #(
  parameter int DATA_W      = 64,
  parameter int FRAME_BYTES = 98,
  parameter int RSV_LO      = 74,
  parameter int RSV_BYTES   = 4,
  parameter int CNT_W       = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fire_i,
  input  logic                      cap_en_i,
  input  logic [CNT_W-1:0]          beat_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [DATA_W/8-1:0]       keep_i,
  output logic [(FRAME_BYTES-RSV_BYTES)*8-1:0] kept_o
);
  localparam int KEEP_W = DATA_W / 8;
  localparam int RSV_HI = RSV_LO + RSV_BYTES;

  for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
    if (b < RSV_LO || b >= RSV_HI) begin : g_store
      localparam int KI   = (b < RSV_LO) ? b : b - RSV_BYTES;
      localparam int BEAT = b / KEEP_W;
      localparam int LANE = b % KEEP_W;
      logic [7:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) byte_q <= '0;
        else if (fire_i && cap_en_i && beat_i == CNT_W'(BEAT) && keep_i[LANE])
          byte_q <= data_i[8*LANE +: 8];
      end
      assign kept_o[8*KI +: 8] = byte_q;
    end
  end
endmodule

// File: rtl/pcx_out_stage.sv
module pcx_out_stage
  import eth_pcx_pkg::*;
#(
  parameter int N_CH      = 12,
  parameter int CH_BYTES  = 5,
  parameter int SIG_BYTES = 20,
  parameter int KEPT      = 94
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         done_i,
  input  logic [KEPT*8-1:0]            kept_i,
  output logic                         valid_o,
  output logic [N_CH*CH_BYTES*8-1:0]   ch_o,
  output logic [SIG_BYTES*8-1:0]       sig_o,
  output logic [47:0]                  dst_o,
  output logic [47:0]                  src_o,
  output logic [15:0]                  type_o
);
  localparam int CH_W    = N_CH * CH_BYTES * 8;
  localparam int SIG_OFS = HDR_BYTES + N_CH * CH_BYTES;

  logic [47:0] dst_n, src_n;
  logic        done_q;

  for (genvar i = 0; i < 6; i++) begin : g_mac
    assign dst_n[8*(5-i) +: 8] = kept_i[8*i +: 8];
    assign src_n[8*(5-i) +: 8] = kept_i[8*(6+i) +: 8];
  end

  // one extra edge so the final beat's bytes are in the buffer before copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      valid_o <= 1'b0;
      ch_o    <= '0;
      sig_o   <= '0;
      dst_o   <= '0;
      src_o   <= '0;
      type_o  <= '0;
    end else begin
      done_q  <= done_i;
      valid_o <= done_q;
      if (done_q) begin
        ch_o   <= kept_i[8*HDR_BYTES +: CH_W];
        sig_o  <= kept_i[8*SIG_OFS +: SIG_BYTES*8];
        dst_o  <= dst_n;
        src_o  <= src_n;
        type_o <= {kept_i[8*TYPE_OFS +: 8], kept_i[8*(TYPE_OFS+1) +: 8]};
      end
    end
  end
endmodule

// File: rtl/eth_payload_fanout.sv
module eth_payload_fanout
  import eth_pcx_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int N_CH      = 12,
  parameter int CH_BYTES  = 5,
  parameter int RSV_BYTES = 4,
  parameter int SIG_BYTES = 20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [15:0]                 cfg_type_i,
  input  logic                        s_tvalid_i,
  output logic                        s_tready_o,
  input  logic [DATA_W-1:0]           s_tdata_i,
  input  logic [DATA_W/8-1:0]         s_tkeep_i,
  input  logic                        s_tlast_i,
  output logic                        ch_valid_o,
  output logic [N_CH*CH_BYTES*8-1:0]  ch_data_o,
  output logic [SIG_BYTES*8-1:0]      sig_o,
  output logic [47:0]                 dst_mac_o,
  output logic [47:0]                 src_mac_o,
  output logic [15:0]                 type_o,
  output logic                        err_o
);
  localparam int KEEP_W      = DATA_W / 8;
  localparam int PAY_BYTES   = N_CH * CH_BYTES + RSV_BYTES + SIG_BYTES;
  localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES;
  localparam int END_BYTE    = FRAME_BYTES - 1;
  localparam int LAST_BEAT   = END_BYTE / KEEP_W;
  localparam int LAST_LANE   = END_BYTE % KEEP_W;
  localparam int TYPE_BEAT   = TYPE_OFS / KEEP_W;
  localparam int TYPE_LANE   = TYPE_OFS % KEEP_W;
  localparam int RSV_LO      = HDR_BYTES + N_CH * CH_BYTES;
  localparam int KEPT        = FRAME_BYTES - RSV_BYTES;
  localparam int CNT_W       = $clog2(LAST_BEAT + 2);

  logic             fire;
  logic [CNT_W-1:0] beat;
  logic             cap_en, done, err_pulse, err_q;
  logic [KEPT*8-1:0] kept;

  assign s_tready_o = 1'b1;
  assign fire       = s_tvalid_i;
  assign err_o      = err_q;

  pcx_frame_tracker #(
    .LAST_BEAT (LAST_BEAT),
    .TYPE_BEAT (TYPE_BEAT),
    .CNT_W     (CNT_W)
  ) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .last_i      (s_tlast_i),
    .keep_type_i (s_tkeep_i[TYPE_LANE+1]),
    .keep_end_i  (s_tkeep_i[LAST_LANE]),
    .type_val_i  ({s_tdata_i[8*TYPE_LANE +: 8], s_tdata_i[8*(TYPE_LANE+1) +: 8]}),
    .cfg_type_i  (cfg_type_i),
    .beat_o      (beat),
    .cap_en_o    (cap_en),
    .done_o      (done),
    .err_o       (err_pulse)
  );

  pcx_byte_capture #(
    .DATA_W      (DATA_W),
    .FRAME_BYTES (FRAME_BYTES),
    .RSV_LO      (RSV_LO),
    .RSV_BYTES   (RSV_BYTES),
    .CNT_W       (CNT_W)
  ) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .cap_en_i (cap_en),
    .beat_i   (beat),
    .data_i   (s_tdata_i),
    .keep_i   (s_tkeep_i),
    .kept_o   (kept)
  );

  pcx_out_stage #(
    .N_CH      (N_CH),
    .CH_BYTES  (CH_BYTES),
    .SIG_BYTES (SIG_BYTES),
    .KEPT      (KEPT)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .kept_i  (kept),
    .valid_o (ch_valid_o),
    .ch_o    (ch_data_o),
    .sig_o   (sig_o),
    .dst_o   (dst_mac_o),
    .src_o   (src_mac_o),
    .type_o  (type_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_pulse;
  end

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid_o |=> !ch_valid_o);
  assert_hold_between_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_valid_o |-> $stable(ch_data_o) && $stable(sig_o));
  assert_err_on_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(s_tvalid_i && s_tlast_i));
  assert_type_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid_o |-> type_o == cfg_type_i);
  assert_end_lane_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid_o |-> $past(s_tvalid_i && s_tkeep_i[LAST_LANE], 2));
endmodule

// File: tb/eth_payload_fanout_bench.sv
`timescale 1ns/1ps
module eth_payload_fanout_bench;
  localparam logic [15:0] CFG = 16'h88B5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tvalid = 1'b0, tlast = 1'b0;
  logic [63:0]  tdata = '0;
  logic [7:0]   tkeep = '0;
  logic         tready, ch_valid, err;
  logic [479:0] ch_data;
  logic [159:0] sig;
  logic [47:0]  dst, src;
  logic [15:0]  ty;

  always #2.5 clk = ~clk;

  eth_payload_fanout u_eth_payload_fanout (
    .clk_i(clk), .rst_ni(rst_n), .cfg_type_i(CFG),
    .s_tvalid_i(tvalid), .s_tready_o(tready), .s_tdata_i(tdata),
    .s_tkeep_i(tkeep), .s_tlast_i(tlast),
    .ch_valid_o(ch_valid), .ch_data_o(ch_data), .sig_o(sig),
    .dst_mac_o(dst), .src_mac_o(src), .type_o(ty), .err_o(err)
  );

  int total = 0, fails = 0;
  int dut_strobes = 0, dut_errs = 0;
  bit finished = 0;
  bit cmp_on = 0;

  task automatic check(input bit ok, input string what, input logic [479:0] act,
                       input logic [479:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // reference model
  logic [7:0]   mq[$];
  bit           m_done = 0, m_rej = 0, m_pend = 0;
  logic         e_valid = 0, e_err = 0;
  logic [479:0] e_ch = '0, p_ch = '0;
  logic [159:0] e_sig = '0, p_sig = '0;
  logic [47:0]  e_dst = '0, e_src = '0, p_dst = '0, p_src = '0;
  logic [15:0]  e_ty = '0, p_ty = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_done = 0; m_rej = 0; m_pend = 0; e_valid = 0; e_err = 0;
    end else begin
      e_valid = m_pend;
      if (m_pend) begin
        e_ch = p_ch; e_sig = p_sig; e_dst = p_dst; e_src = p_src; e_ty = p_ty;
      end
      m_pend = 0;
      e_err = 0;
      if (tvalid) begin
        for (int l = 0; l < 8; l++) if (tkeep[l]) mq.push_back(tdata[8*l +: 8]);
        if (!m_done && !m_rej) begin
          if (mq.size() >= 14 && {mq[12], mq[13]} != CFG) m_rej = 1;
          else if (mq.size() >= 98) begin
            m_done = 1; m_pend = 1;
            for (int p = 0; p < 60; p++) p_ch[8*p +: 8] = mq[14+p];
            for (int j = 0; j < 20; j++) p_sig[8*j +: 8] = mq[78+j];
            for (int i = 0; i < 6; i++) begin
              p_dst[8*(5-i) +: 8] = mq[i];
              p_src[8*(5-i) +: 8] = mq[6+i];
            end
            p_ty = {mq[12], mq[13]};
          end
        end
        if (tlast) begin
          if (!m_done && !m_rej) e_err = 1;
          mq.delete(); m_done = 0; m_rej = 0;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (ch_valid) dut_strobes++;
    if (err) dut_errs++;
    if (cmp_on) begin
      check(tready == 1'b1, "R2 tready", 480'(tready), 480'(1));
      check(ch_valid == e_valid, "R7 strobe timing", 480'(ch_valid), 480'(e_valid));
      check(err == e_err, "R8 error pulse", 480'(err), 480'(e_err));
      check(ch_data == e_ch, "R5 channel data", ch_data, e_ch);
      check(sig == e_sig, "R6 signature", 480'(sig), 480'(e_sig));
      check({dst, src, ty} == {e_dst, e_src, e_ty}, "R3 header fields",
            480'({dst, src, ty}), 480'({e_dst, e_src, e_ty}));
    end
  end

  logic [7:0] fr[$];

  task automatic mk(input int len, input logic [15:0] t, input int seed);
    fr.delete();
    for (int i = 0; i < len; i++) begin
      if (i == 12)      fr.push_back(t[15:8]);
      else if (i == 13) fr.push_back(t[7:0]);
      else              fr.push_back(8'(i * 37 + seed * 101 + 5));
    end
  endtask

  task automatic send(input int gap, input bit idle_after);
    int nb;
    nb = (fr.size() + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      if (gap != 0 && (b % gap) == 1) begin
        @(negedge clk); tvalid = 0; tlast = 0;
      end
      @(negedge clk);
      tvalid = 1; tdata = '0; tkeep = '0;
      for (int l = 0; l < 8; l++)
        if (b*8 + l < fr.size()) begin
          tdata[8*l +: 8] = fr[b*8 + l];
          tkeep[l] = 1'b1;
        end
      tlast = (b == nb - 1);
    end
    if (idle_after) begin
      @(negedge clk); tvalid = 0; tlast = 0; tkeep = '0;
    end
  endtask

  task automatic settle();
    @(negedge clk); tvalid = 0; tlast = 0; tkeep = '0;
    repeat (5) @(negedge clk);
  endtask

  logic [479:0] ch_keep;

  initial begin
    repeat (3) @(negedge clk);
    check(ch_valid == 0 && err == 0 && ch_data == '0 && sig == '0 && dst == '0,
          "R1 outputs during reset", 480'({ch_valid, err}), 480'(0));
    rst_n = 1;
    @(negedge clk);
    check(ch_valid == 0 && err == 0 && ch_data == '0 && ty == '0,
          "R1 outputs after reset", 480'({ch_valid, err, ty}), 480'(0));
    cmp_on = 1;

    mk(98, CFG, 1); send(0, 1); settle();
    check(dut_strobes == 1, "R7 one strobe per frame", 480'(dut_strobes), 480'(1));
    check(ch_data[7:0] == fr[14], "R5 channel 0 first byte", 480'(ch_data[7:0]), 480'(fr[14]));
    check(ch_data[479:472] == fr[73], "R5 channel 11 last byte",
          480'(ch_data[479:472]), 480'(fr[73]));
    check(sig[7:0] == fr[78] && sig[159:152] == fr[97], "R6 signature ends",
          480'({sig[159:152], sig[7:0]}), 480'({fr[97], fr[78]}));
    check(dst[47:40] == fr[0] && src[7:0] == fr[11] && ty == CFG, "R3 header order",
          480'({dst[47:40], src[7:0], ty}), 480'({fr[0], fr[11], CFG}));

    mk(98, CFG, 2); send(3, 1); settle();
    check(dut_strobes == 2, "R10 frame with idle gaps", 480'(dut_strobes), 480'(2));

    mk(200, CFG, 3); send(0, 1); settle();
    check(dut_strobes == 3 && dut_errs == 0, "R9 long frame",
          480'({dut_strobes, dut_errs}), 480'({32'd3, 32'd0}));

    ch_keep = ch_data;
    mk(120, 16'h0800, 4); send(0, 1); settle();
    check(dut_strobes == 3 && dut_errs == 0, "R4 foreign type dropped",
          480'({dut_strobes, dut_errs}), 480'({32'd3, 32'd0}));
    check(ch_data == ch_keep, "R4 outputs unchanged", ch_data, ch_keep);

    mk(60, CFG, 5); send(0, 1); settle();
    check(dut_errs == 1 && dut_strobes == 3, "R8 short frame error",
          480'({dut_strobes, dut_errs}), 480'({32'd3, 32'd1}));
    check(ch_data == ch_keep, "R8 outputs unchanged", ch_data, ch_keep);

    mk(97, CFG, 6); send(0, 1); settle();
    check(dut_errs == 2 && dut_strobes == 3, "R11 missing final lane",
          480'({dut_strobes, dut_errs}), 480'({32'd3, 32'd2}));

    mk(10, 16'h0000, 7); send(0, 1); settle();
    check(dut_errs == 3, "R8 frame shorter than header", 480'(dut_errs), 480'(3));

    mk(14, 16'h1234, 8); send(0, 1); settle();
    check(dut_errs == 3 && dut_strobes == 3, "R4 header-only foreign frame",
          480'({dut_strobes, dut_errs}), 480'({32'd3, 32'd3}));

    mk(98, CFG, 9); send(0, 0);
    mk(104, CFG, 10); send(0, 1); settle();
    check(dut_strobes == 5 && dut_errs == 3, "R7 back-to-back frames",
          480'({dut_strobes, dut_errs}), 480'({32'd5, 32'd3}));
    check(ch_data[7:0] == fr[14], "R5 second frame data", 480'(ch_data[7:0]), 480'(fr[14]));

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule